// File: doc/BRIEF.md
# Masked Arithmetic-Logic Unit with Protected Carry

This block is a compute stage for values that never appear in the clear outside it. Each operand arrives XOR-masked, together with its own mask. The caller also supplies a fresh mask for the result. Inside, the unit strips the operand masks and applies one of eight word operations or one of four carry-related commands. It returns the outcome under the fresh mask one clock later. A carry bit lives only inside the unit. An add that records its carry, followed by an add that consumes and re-records it, lets software chain additions wider than one word. The carry can be saved out as a masked word and later reloaded from one, which covers context switches.

The block has no states beyond its carry bit and its output register. Each accepted command takes exactly one clock: IDLE (no `in_valid`) leaves the output valid low. ISSUE (`in_valid` high) registers a masked result and raises `out_valid` on the next clock.

Top module: `malu_top`

## Requirements
- R1: A command accepted with `in_valid` high at a rising edge produces `out_valid` high and its result on `res_m` after exactly that edge; `out_valid` is low after any edge where `in_valid` was low.
- R2: The plain operands are `opa_m ^ mask_a` and `opb_m ^ mask_b`, and `res_m` equals the plain result XOR the `mask_out` presented with the command.
- R3: Codes 0, 1 and 2 give the bitwise XOR, AND and OR of the plain operands.
- R4: Code 3 gives A+B and code 4 gives A−B, both modulo 2^32.
- R5: Code 5 shifts A left and code 6 shifts A right (zero fill), by the amount held in bits 4:0 of plain B; higher bits of B are ignored.
- R6: Code 7 rotates A right by bits 4:0 of plain B.
- R7: Code 8 gives A+B modulo 2^32 and stores the carry out of bit 31 into the carry bit.
- R8: Code 9 gives A+B+carry modulo 2^32 and stores its carry out into the carry bit, so a code 8 on low words followed by code 9 on high words forms a 64-bit sum.
- R9: Code 10 returns a word whose bit 0 is the carry bit and whose bits 31:1 are zero, masked as in R2.
- R10: Code 11 loads the carry bit from bit 0 of plain A and returns zero.
- R11: Reset clears the carry bit and `out_valid`. Codes other than 8, 9 and 11 leave the carry bit unchanged, and codes 12 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command present this cycle |
| op | input | 4 | Operation code |
| opa_m | input | 32 | Masked operand A |
| opb_m | input | 32 | Masked operand B |
| mask_a | input | 32 | Mask of operand A |
| mask_b | input | 32 | Mask of operand B |
| mask_out | input | 32 | Fresh mask for the result |
| out_valid | output | 1 | Result valid |
| res_m | output | 32 | Result under `mask_out` |

## Verification
The bench targets shift and rotate amounts of 0 and 31, and amounts carried in the upper bits of B. A design that used the whole operand would return zero there, and one that rotated through a shorter width would return a shifted value. It targets the all-ones plus one carry and a 64-bit chain. Dropping or double-counting the carry corrupts the high word. It reads the carry after plain adds and after undefined codes, where a design that let other operations touch the bit would report a wrong value. It restores the carry from a masked word whose mask flips bit 0, which exposes a design that loaded the raw masked bit.

// File: rtl/malu_pkg.sv
package malu_pkg;

    typedef enum logic [3:0] {
        OP_XOR   = 4'd0,
        OP_AND   = 4'd1,
        OP_OR    = 4'd2,
        OP_ADD   = 4'd3,
        OP_SUB   = 4'd4,
        OP_SLL   = 4'd5,
        OP_SRL   = 4'd6,
        OP_ROTR  = 4'd7,
        OP_ADDCC = 4'd8,
        OP_ADDX  = 4'd9,
        OP_RDCF  = 4'd10,
        OP_WRCF  = 4'd11
    } op_e;

endpackage

// File: rtl/malu_unmask.sv
module malu_unmask #(
    parameter int W = 32,
    parameter int N = 2
) (
    input  logic [N-1:0][W-1:0] val_m,
    input  logic [N-1:0][W-1:0] mask,
    output logic [N-1:0][W-1:0] plain
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        assign plain[i] = val_m[i] ^ mask[i];
    end
endmodule

// File: rtl/malu_core.sv
module malu_core
    import malu_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] raw,
    output logic         cout,
    output logic         cwe
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0]   amt;
    logic [W:0]       sum;
    logic [2*W-1:0]   dbl;

    assign amt = b[SHW-1:0];
    assign dbl = {a, a} >> amt;
    assign sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, (op == OP_ADDX) & cin};

    always_comb begin
        raw  = '0;
        cout = cin;
        cwe  = 1'b0;
        unique case (op)
            OP_XOR:   raw = a ^ b;
            OP_AND:   raw = a & b;
            OP_OR:    raw = a | b;
            OP_ADD:   raw = a + b;
            OP_SUB:   raw = a - b;
            OP_SLL:   raw = a << amt;
            OP_SRL:   raw = a >> amt;
            OP_ROTR:  raw = dbl[W-1:0];
            OP_ADDCC, OP_ADDX: begin
                raw  = sum[W-1:0];
                cout = sum[W];
                cwe  = 1'b1;
            end
            OP_RDCF:  raw = {{(W-1){1'b0}}, cin};
            OP_WRCF: begin
                cout = a[0];
                cwe  = 1'b1;
            end
            default:  raw = '0;
        endcase
    end
endmodule

// File: rtl/malu_cflag.sv
module malu_cflag (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/malu_top.sv
module malu_top
    import malu_pkg::*;
#(
    parameter int W  = 32,
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [OW-1:0] op,
    input  logic [W-1:0]  opa_m,
    input  logic [W-1:0]  opb_m,
    input  logic [W-1:0]  mask_a,
    input  logic [W-1:0]  mask_b,
    input  logic [W-1:0]  mask_out,
    output logic          out_valid,
    output logic [W-1:0]  res_m
);
    logic [1:0][W-1:0] plain;
    logic [W-1:0]      raw;
    logic              carry_q;
    logic              carry_d;
    logic              carry_we;
    op_e               op_dec;

    assign op_dec = op_e'(op);

    malu_unmask #(.W(W), .N(2)) u_unmask (
        .val_m ({opb_m, opa_m}),
        .mask  ({mask_b, mask_a}),
        .plain (plain)
    );

    malu_core #(.W(W)) u_core (
        .op   (op_dec),
        .a    (plain[0]),
        .b    (plain[1]),
        .cin  (carry_q),
        .raw  (raw),
        .cout (carry_d),
        .cwe  (carry_we)
    );

    malu_cflag u_cflag (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (in_valid & carry_we),
        .d     (carry_d),
        .q     (carry_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_m     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) res_m <= raw ^ mask_out;
        end
    end
endmodule

// File: rtl/malu_chk.sv
module malu_chk #(
    parameter int W  = 32,
    parameter int OW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [OW-1:0] op,
    input logic [W-1:0]  opa_m,
    input logic [W-1:0]  opb_m,
    input logic [W-1:0]  mask_a,
    input logic [W-1:0]  mask_b,
    input logic [W-1:0]  mask_out,
    input logic          out_valid,
    input logic [W-1:0]  res_m,
    input logic          carry_q
);
    logic writes_flag;
    assign writes_flag = (op == OW'(8)) || (op == OW'(9)) || (op == OW'(11));

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_xor_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OW'(0)) |=>
        ((res_m ^ $past(mask_out)) == ($past(opa_m ^ mask_a) ^ $past(opb_m ^ mask_b))));

    p_read_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OW'(10)) |=>
        ((res_m ^ $past(mask_out)) == {{(W-1){1'b0}}, $past(carry_q)}));

    p_restore_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OW'(11)) |=> (carry_q == $past(opa_m[0] ^ mask_a[0])));

    p_flag_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && writes_flag) |=> $stable(carry_q));
endmodule

bind malu_top malu_chk #(.W(W), .OW(OW)) u_chk (.*);

// File: tb/malu_top_tb.sv
`timescale 1ns/1ps
module malu_top_tb;
    localparam int W = 32;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   op = '0;
    logic [W-1:0] opa_m = '0, opb_m = '0, mask_a = '0, mask_b = '0, mask_out = '0;
    logic         out_valid;
    logic [W-1:0] res_m;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    logic  mflag    = 1'b0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    malu_top u_dut (.*);

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        logic [4:0] n;
        n = b[4:0];
        case (c)
            4'd0:  return a ^ b;
            4'd1:  return a & b;
            4'd2:  return a | b;
            4'd3:  return a + b;
            4'd4:  return a - b;
            4'd5:  return a << n;
            4'd6:  return a >> n;
            4'd7:  return (a >> n) | ((n == 0) ? '0 : (a << (6'd32 - {1'b0, n})));
            4'd8:  begin s = {1'b0, a} + {1'b0, b}; mflag = s[W]; return s[W-1:0]; end
            4'd9:  begin s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, mflag}; mflag = s[W]; return s[W-1:0]; end
            4'd10: return {{(W-1){1'b0}}, mflag};
            4'd11: begin mflag = a[0]; return '0; end
            default: return '0;
        endcase
    endfunction

    // driver: presents one command and queues its expected masked result
    task automatic issue(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        logic [W-1:0] ma, mb, mo;
        item_t it;
        ma = $urandom(); mb = $urandom(); mo = $urandom();
        @(negedge clk);
        in_valid = 1'b1; op = c;
        opa_m = a ^ ma; opb_m = b ^ mb;
        mask_a = ma; mask_b = mb; mask_out = mo;
        it.exp = model(c, a, b) ^ mo;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected out_valid", res_m, '0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(res_m == it.exp, it.tag, res_m, it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired act=%h exp=%h", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R11 reset out_valid", {31'b0, out_valid}, '0);
        rst_n = 1'b1;
        idle(1);

        issue(4'd10, '0, '0, "R11 reset carry reads 0");
        issue(4'd0, 32'hF0F0_1234, 32'h0FF0_4321, "R3 xor");
        issue(4'd1, 32'hF0F0_1234, 32'h0FF0_4321, "R3 and");
        issue(4'd2, 32'hF0F0_1234, 32'h0FF0_4321, "R3 or");
        issue(4'd3, 32'hFFFF_FFFF, 32'd2, "R4 add wraps");
        issue(4'd4, 32'd1, 32'd2, "R4 sub wraps");
        issue(4'd5, 32'h8000_0001, 32'd37, "R5 sll ignores high amount bits");
        issue(4'd6, 32'h8000_0001, 32'd31, "R5 srl by 31");
        issue(4'd5, 32'h1234_5678, 32'd0, "R5 sll by 0");
        issue(4'd7, 32'h1234_5678, 32'd0, "R6 rotr by 0");
        issue(4'd7, 32'h0000_0001, 32'd1, "R6 rotr by 1");
        issue(4'd7, 32'h8000_0001, 32'hFFFF_FFFF, "R6 rotr by 31");
        issue(4'd8, 32'hFFFF_FFFF, 32'd1, "R7 addcc carry out");
        issue(4'd10, '0, '0, "R9 read carry 1");
        issue(4'd3, 32'd1, 32'd1, "R11 add keeps carry");
        issue(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11 undefined code zero");
        issue(4'd10, '0, '0, "R11 carry kept after add and undefined");
        issue(4'd9, 32'd0, 32'd0, "R8 addx consumes carry");
        issue(4'd10, '0, '0, "R8 addx stored carry 0");
        issue(4'd8, 32'h8000_0000, 32'h8000_0000, "R8 chain low word");
        issue(4'd9, 32'h0000_0001, 32'h0000_0002, "R8 chain high word");
        issue(4'd11, 32'h0000_0001, '0, "R10 restore returns zero");
        issue(4'd10, '0, '0, "R10 restored carry 1");
        issue(4'd11, 32'hFFFF_FFFE, '0, "R10 restore 0");
        issue(4'd10, '0, '0, "R10 restored carry 0");
        idle(2);
        check(sb.size() == 0, "R1 one-cycle latency drained", W'(sb.size()), '0);
        check(out_valid == 1'b0, "R1 idle out_valid low", {31'b0, out_valid}, '0);

        for (int i = 0; i < 600; i++) begin
            issue(4'($urandom_range(0, 15)), $urandom(), $urandom(), "R2 random masked op");
            if (i % 50 == 0) idle(1);
        end
        idle(2);
        check(sb.size() == 0, "R1 random drained", W'(sb.size()), '0);
        finish_run();
    end
endmodule